// File: doc/BRIEF.md
# AUX Reply Status Classifier

This block judges a finished auxiliary-channel reply. The receiver front end supplies its error flags, the number of bytes it collected and the first byte it collected. The block turns these into one transaction verdict: success, timeout, bad reply or sink unplugged. On success it also sorts the reply code in the first byte into a reply class and reports how many payload bytes follow that byte. For an acknowledged reply it can also flag a payload that will not fit in the caller's buffer.

A `launch` strobe starts a cycle watchdog when a request goes out. An `evaluate` strobe marks the moment the receiver says it is done. If `evaluate` does not arrive within `TIMEOUT_CYCLES` cycles of `launch`, the block produces a timeout verdict by itself. Each verdict is registered and announced by a one-cycle `resultValid` pulse.

Top module: `aux_reply_classifier`

## Requirements
- R1: `unplugged` high when a verdict is taken gives result 3 (unplugged), whatever the other inputs are, and also when the verdict comes from the watchdog.
- R2: If R1 does not apply, either `rxTimeoutState` or `rxTimeout` gives result 1 (timeout). This holds even when framing-error flags are also set.
- R3: If R1 and R2 do not apply, any of `rxBadStop`, `rxNoDetect`, `rxBadHigh` or `rxBadLow` gives result 2 (bad reply).
- R4: `rxMinCountViol` has no effect on any output.
- R5: If no flag applies, a `rxByteCount` of 0 gives result 2. Any other count gives result 0 (success) with `payloadCount` = `rxByteCount` - 1. `payloadCount` is 0 for every result other than success.
- R6: On success, `replyClass` is decoded from `firstByte[7:4]`: 0 gives ACK (0), 1 gives NACK (1), 2 gives DEFER (2), 4 gives I2C NACK (3), 8 gives I2C DEFER (4), and any other value gives INVALID (5). For any result other than success, `replyClass` is NONE (7).
- R7: `overflowErr` is 1 only on success with class ACK and `payloadCount` > `bufSize`.
- R8: If `launch` is sampled at edge 0 and `evaluate` is low at edges 1 through `TIMEOUT_CYCLES`, a timeout verdict is registered at edge `TIMEOUT_CYCLES`. An `evaluate` sampled at that edge or earlier takes precedence and disarms the watchdog. After firing, the watchdog stays quiet until the next `launch`.
- R9: A verdict taken at an edge is visible on the outputs right after that edge, with `resultValid` high for exactly one cycle. After reset `resultValid` is 0, `result` is 0, `replyClass` is 7, and `payloadCount` and `overflowErr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launch | input | 1 | Request sent; arms the watchdog |
| evaluate | input | 1 | Receiver done; classify the reply now |
| unplugged | input | 1 | Hot-plug disconnect seen |
| rxTimeoutState | input | 1 | Receiver timeout-state flag |
| rxTimeout | input | 1 | Receiver timeout flag |
| rxBadStop | input | 1 | Invalid stop pattern |
| rxNoDetect | input | 1 | Receiver saw no reply |
| rxBadHigh | input | 1 | Invalid high-level symbol |
| rxBadLow | input | 1 | Invalid low-level symbol |
| rxMinCountViol | input | 1 | Debug-only minimum-count flag, ignored |
| rxByteCount | input | CNT_W | Bytes received, status byte included |
| firstByte | input | 8 | First received byte (reply code in upper nibble) |
| bufSize | input | CNT_W | Capacity of the caller's buffer |
| resultValid | output | 1 | One-cycle verdict strobe |
| result | output | 2 | 0 success, 1 timeout, 2 bad reply, 3 unplugged |
| replyClass | output | 3 | Reply class per R6 |
| payloadCount | output | CNT_W | Payload bytes excluding the status byte |
| overflowErr | output | 1 | ACK payload exceeds `bufSize` |

## Verification
The assertions assume that the flag, count, byte and buffer-size inputs are stable around the edge that samples `evaluate`. They also assume that `evaluate` is a single-cycle strobe. The bench changes inputs only on falling edges and raises `evaluate` for exactly one cycle per vector. It drops `evaluate` before looking at the outputs, and `launch` is held for one cycle only. The watchdog scenarios keep the flags quiet or set them deliberately, so the verdict taken at expiry is fully determined.

// File: rtl/aux_rc_pkg.sv
package aux_rc_pkg;

  typedef enum logic [1:0] {
    RES_OK        = 2'd0,
    RES_TIMEOUT   = 2'd1,
    RES_BADREPLY  = 2'd2,
    RES_UNPLUGGED = 2'd3
  } xferResult_t;

  typedef enum logic [2:0] {
    CLS_ACK       = 3'd0,
    CLS_NACK      = 3'd1,
    CLS_DEFER     = 3'd2,
    CLS_I2C_NACK  = 3'd3,
    CLS_I2C_DEFER = 3'd4,
    CLS_INVALID   = 3'd5,
    CLS_NONE      = 3'd7
  } replyClass_t;

  typedef struct packed {
    logic capture;  // receiver finished: classify the live inputs
    logic expire;   // watchdog ran out with no evaluate
  } ctrlStrobes_t;

endpackage

// File: rtl/aux_rc_ctrl.sv
module aux_rc_ctrl
  import aux_rc_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 1000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         launch,
  input  logic         evaluate,
  output ctrlStrobes_t strobes
);
  localparam int TMR_W = (TIMEOUT_CYCLES > 1) ? $clog2(TIMEOUT_CYCLES) : 1;
  localparam logic [TMR_W-1:0] LAST = TMR_W'(TIMEOUT_CYCLES - 1);

  logic             armed;
  logic [TMR_W-1:0] tick;
  logic             limitHit;

  assign limitHit        = armed && (tick == LAST);
  assign strobes.capture = evaluate;
  assign strobes.expire  = limitHit && !evaluate;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      tick  <= '0;
    end else if (launch) begin
      armed <= 1'b1;
      tick  <= '0;
    end else if (evaluate || limitHit) begin
      armed <= 1'b0;
      tick  <= '0;
    end else if (armed) begin
      tick  <= tick + 1'b1;
    end
  end

  // The watchdog fires at most once per launch.
  assert_single_expire_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.expire |=> !strobes.expire);

  // An evaluate in the expiry cycle always wins over the watchdog.
  assert_evaluate_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evaluate |-> !strobes.expire);

  // The count never passes the last permitted tick.
  always_comb begin
    if (rst_n) assert_tick_bound_R8: assert (tick <= LAST);
  end

endmodule

// File: rtl/aux_rc_datapath.sv
module aux_rc_datapath
  import aux_rc_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrlStrobes_t     strobes,
  input  logic             unplugged,
  input  logic             rxTimeoutState,
  input  logic             rxTimeout,
  input  logic             rxBadStop,
  input  logic             rxNoDetect,
  input  logic             rxBadHigh,
  input  logic             rxBadLow,
  input  logic [CNT_W-1:0] rxByteCount,
  input  logic [7:0]       firstByte,
  input  logic [CNT_W-1:0] bufSize,
  output logic             resultValid,
  output logic [1:0]       result,
  output logic [2:0]       replyClass,
  output logic [CNT_W-1:0] payloadCount,
  output logic             overflowErr
);
  xferResult_t      resNext;
  replyClass_t      clsNext;
  replyClass_t      codeClass;
  logic [CNT_W-1:0] payNext;
  logic             ovfNext;
  logic             framingErr;
  logic             take;

  xferResult_t      resQ;
  replyClass_t      clsQ;

  assign take       = strobes.capture || strobes.expire;
  assign framingErr = rxBadStop || rxNoDetect || rxBadHigh || rxBadLow;

  always_comb begin
    unique case (firstByte[7:4])
      4'd0:    codeClass = CLS_ACK;
      4'd1:    codeClass = CLS_NACK;
      4'd2:    codeClass = CLS_DEFER;
      4'd4:    codeClass = CLS_I2C_NACK;
      4'd8:    codeClass = CLS_I2C_DEFER;
      default: codeClass = CLS_INVALID;
    endcase
  end

  always_comb begin
    if (unplugged)                        resNext = RES_UNPLUGGED;
    else if (strobes.expire)              resNext = RES_TIMEOUT;
    else if (rxTimeoutState || rxTimeout) resNext = RES_TIMEOUT;
    else if (framingErr)                  resNext = RES_BADREPLY;
    else if (rxByteCount == '0)           resNext = RES_BADREPLY;
    else                                  resNext = RES_OK;

    clsNext = (resNext == RES_OK) ? codeClass : CLS_NONE;
    payNext = (resNext == RES_OK) ? rxByteCount - 1'b1 : '0;
    ovfNext = (clsNext == CLS_ACK) && (payNext > bufSize);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resultValid  <= 1'b0;
      resQ         <= RES_OK;
      clsQ         <= CLS_NONE;
      payloadCount <= '0;
      overflowErr  <= 1'b0;
    end else begin
      resultValid <= take;
      if (take) begin
        resQ         <= resNext;
        clsQ         <= clsNext;
        payloadCount <= payNext;
        overflowErr  <= ovfNext;
      end
    end
  end

  assign result     = resQ;
  assign replyClass = clsQ;

  assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    resultValid |-> $past(strobes.capture || strobes.expire));

  assert_unplug_dominates_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (take && unplugged) |=> (result == 2'd3));

  assert_expire_is_failure_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.expire |=> (result != 2'd0));

  assert_overflow_only_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (resultValid && overflowErr) |-> (result == 2'd0 && replyClass == 3'd0));

  assert_no_payload_on_fail_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (resultValid && result != 2'd0) |-> (payloadCount == '0 && replyClass == 3'd7));

endmodule

// File: rtl/aux_reply_classifier.sv
module aux_reply_classifier
  import aux_rc_pkg::*;
#(
  parameter int CNT_W          = 5,
  parameter int TIMEOUT_CYCLES = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic             evaluate,
  input  logic             unplugged,
  input  logic             rxTimeoutState,
  input  logic             rxTimeout,
  input  logic             rxBadStop,
  input  logic             rxNoDetect,
  input  logic             rxBadHigh,
  input  logic             rxBadLow,
  input  logic             rxMinCountViol,
  input  logic [CNT_W-1:0] rxByteCount,
  input  logic [7:0]       firstByte,
  input  logic [CNT_W-1:0] bufSize,
  output logic             resultValid,
  output logic [1:0]       result,
  output logic [2:0]       replyClass,
  output logic [CNT_W-1:0] payloadCount,
  output logic             overflowErr
);
  ctrlStrobes_t strobes;
  logic         unusedDebug;

  // The minimum-count flag is a debug aid only and feeds no logic.
  assign unusedDebug = rxMinCountViol;

  aux_rc_ctrl #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch   (launch),
    .evaluate (evaluate),
    .strobes  (strobes)
  );

  aux_rc_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk            (clk),
    .rst_n          (rst_n),
    .strobes        (strobes),
    .unplugged      (unplugged),
    .rxTimeoutState (rxTimeoutState),
    .rxTimeout      (rxTimeout),
    .rxBadStop      (rxBadStop),
    .rxNoDetect     (rxNoDetect),
    .rxBadHigh      (rxBadHigh),
    .rxBadLow       (rxBadLow),
    .rxByteCount    (rxByteCount),
    .firstByte      (firstByte),
    .bufSize        (bufSize),
    .resultValid    (resultValid),
    .result         (result),
    .replyClass     (replyClass),
    .payloadCount   (payloadCount),
    .overflowErr    (overflowErr)
  );

endmodule

// File: tb/sim_aux_reply_classifier.sv
`timescale 1ns/1ps
module sim_aux_reply_classifier;
  localparam int CW = 5;
  localparam int TO = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic launch = 1'b0, evaluate = 1'b0;
  logic [7:0] flags = '0;   // [0]unplug [1]tmoState [2]tmo [3]stop [4]nodet [5]hi [6]lo [7]minViol
  logic [CW-1:0] rxByteCount = '0, bufSize = '0;
  logic [7:0] firstByte = '0;
  logic resultValid, overflowErr;
  logic [1:0] result;
  logic [2:0] replyClass;
  logic [CW-1:0] payloadCount;

  int vectors = 0;
  int fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  aux_reply_classifier #(.CNT_W(CW), .TIMEOUT_CYCLES(TO)) u0 (
    .clk(clk), .rst_n(rst_n), .launch(launch), .evaluate(evaluate),
    .unplugged(flags[0]), .rxTimeoutState(flags[1]), .rxTimeout(flags[2]),
    .rxBadStop(flags[3]), .rxNoDetect(flags[4]), .rxBadHigh(flags[5]),
    .rxBadLow(flags[6]), .rxMinCountViol(flags[7]),
    .rxByteCount(rxByteCount), .firstByte(firstByte), .bufSize(bufSize),
    .resultValid(resultValid), .result(result), .replyClass(replyClass),
    .payloadCount(payloadCount), .overflowErr(overflowErr));

  task automatic check(string tag, logic [12:0] act, logic [12:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Independent reference for one verdict; packed as {valid,res,cls,pay,ovf}.
  function automatic logic [12:0] refModel(logic [7:0] f, int cnt, int code, int bsz, bit wd);
    int r, c, p;
    bit o;
    if (f[0]) r = 3;
    else if (wd || f[1] || f[2]) r = 1;
    else if (f[3] || f[4] || f[5] || f[6]) r = 2;
    else if (cnt == 0) r = 2;
    else r = 0;
    c = 7; p = 0; o = 0;
    if (r == 0) begin
      p = cnt - 1;
      case (code)
        0: c = 0;  1: c = 1;  2: c = 2;  4: c = 3;  8: c = 4;
        default: c = 5;
      endcase
      o = (c == 0) && (p > bsz);
    end
    return {1'b1, 2'(r), 3'(c), 5'(p), o};
  endfunction

  function automatic string tagFor(logic [7:0] f, int cnt, int code, int bsz);
    if (f[0]) return "R1";
    if (f[1] || f[2]) return "R2";
    if (f[3] || f[4] || f[5] || f[6]) return "R3";
    if (f[7]) return "R4";
    if (cnt == 0) return "R5";
    if (code == 0 && cnt - 1 > bsz) return "R7";
    return "R6";
  endfunction

  task automatic applyVec(logic [7:0] f, int cnt, int code, int bsz);
    @(negedge clk);
    flags = f; rxByteCount = CW'(cnt); bufSize = CW'(bsz);
    firstByte = {4'(code), 4'(cnt * 3)};
    evaluate = 1'b1;
    @(negedge clk);
    evaluate = 1'b0;
    check(tagFor(f, cnt, code, bsz),
          {resultValid, result, replyClass, payloadCount, overflowErr},
          refModel(f, cnt, code, bsz, 1'b0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9", {resultValid, result, replyClass, payloadCount, overflowErr},
          {1'b0, 2'd0, 3'd7, 5'd0, 1'b0});
    rst_n = 1'b1;

    // Flag priority sweep: every flag combination, a few counts and codes.
    for (int f = 0; f < 256; f++)
      for (int ci = 0; ci < 3; ci++)
        for (int code = 0; code < 2; code++)
          applyVec(8'(f), (ci == 0) ? 0 : (ci == 1 ? 1 : 5), code, 3);

    // R9: valid falls one cycle after the verdict.
    @(negedge clk);
    check("R9", {12'd0, resultValid}, 13'd0);

    // Code / count / buffer sweep, clean flags and debug flag alone (R4).
    for (int m = 0; m < 2; m++)
      for (int code = 0; code < 16; code++)
        for (int cnt = 0; cnt < 32; cnt++)
          applyVec(m ? 8'h80 : 8'h00, cnt, code, (code * 5 + cnt * 3) % 32);

    // R8: watchdog expiry with no evaluate.
    @(negedge clk); flags = 8'h00; rxByteCount = 5'd4; firstByte = 8'h00; launch = 1'b1;
    @(negedge clk); launch = 1'b0;
    for (int k = 1; k < TO; k++) begin
      @(negedge clk);
      check("R8", {12'd0, resultValid}, 13'd0);
    end
    @(negedge clk);
    check("R8", {resultValid, result, replyClass, payloadCount, overflowErr},
          refModel(8'h00, 4, 0, 0, 1'b1));
    repeat (2 * TO) begin
      @(negedge clk);
      check("R8", {12'd0, resultValid}, 13'd0);
    end

    // R1: unplug seen at expiry dominates.
    @(negedge clk); launch = 1'b1;
    @(negedge clk); launch = 1'b0;
    repeat (TO - 1) @(negedge clk);
    flags = 8'h01;
    @(negedge clk);
    check("R1", {resultValid, result, replyClass, payloadCount, overflowErr},
          refModel(8'h01, 4, 0, 0, 1'b1));
    flags = 8'h00;

    // R8: evaluate at the last edge beats the watchdog, which is then disarmed.
    @(negedge clk); launch = 1'b1; bufSize = 5'd31;
    @(negedge clk); launch = 1'b0;
    repeat (TO - 1) @(negedge clk);
    evaluate = 1'b1;
    @(negedge clk); evaluate = 1'b0;
    check("R8", {resultValid, result, replyClass, payloadCount, overflowErr},
          refModel(8'h00, 4, 0, 31, 1'b0));
    repeat (2 * TO) begin
      @(negedge clk);
      check("R8", {12'd0, resultValid}, 13'd0);
    end

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule